// File: doc/BRIEF.md
# Adaptive-gain incremental PID compensator

This block closes the digital loop of a switch-mode converter. On every sample strobe it accepts a signed error code: the reference minus the measured output, as delivered by the ADC. It returns an unsigned duty command for the pulse-width modulator one clock later. The control law works in velocity form. Each new command is the previous one plus a weighted sum of the first and second differences of the error and the error itself. All coefficients are integers equal to the real gain times 256, and the command accumulator keeps the same eight fraction bits.

A small classifier watches the error magnitude against a threshold. While the error stays small, the base gains are used. This keeps the loop bandwidth low and the loop quiet. When the error leaves the band, the block records whether it is rising or falling and tracks the largest magnitude seen during that event. It then adds a boost to all three gains, derivative included. The boost is scaled by a four-level ratio of the present magnitude to that peak. When the error returns inside the band, the block enters a settling phase that lasts a fixed number of samples and uses a second, softer boost set with no derivative boost. After that it returns to the base gains and forgets the peak.

Top module: `mapid_comp`

## Requirements
- R1: Reset sets the duty output to 0 and the valid flag to 0, and clears the error history, the accumulator, the peak and the mode. After reset, a first error of 10 gives a duty of 61.
- R2: `duty_valid` is high for exactly the cycle after each clock that samples `sample_stb` high, and low otherwise. `duty` changes only in that cycle.
- R3: In the quiet mode, the accumulator grows by Kp·(e−e1) + Ki·e + Kd·(e−2·e1+e2), where e1 and e2 are the two previous sampled errors and Kp=512, Ki=26, Kd=1024 (scaled by 256).
- R4: The accumulator is clamped to the range 0 to 1023·256, and the duty equals the accumulator shifted right by 8. A long run of large errors therefore settles at 0 or at 1023.
- R5: An error whose magnitude exceeds 12 starts a transient: rising if the error is positive, falling if it is negative. Each gain then receives the boost floor(q·ΔK/4), with ΔKp=179, ΔKi=77 and ΔKd=589. After reset, a first error of 13 gives a duty of 122.
- R6: During a transient, the peak is the largest magnitude seen since the event began. The ratio level q is 4 if 4·|e| ≥ 3·peak, otherwise 3 if 2·|e| ≥ peak, otherwise 2 if 4·|e| ≥ peak, and 1 in all other cases.
- R7: The first sample with magnitude at most 12 after a transient starts the settling phase. For 8 samples the gains are Kp+461, Ki+5 and Kd unchanged. The next small sample uses the base gains and clears the peak.
- R8: A sample over the threshold during the settling phase restarts a transient, and the peak keeps its earlier value.
- R9: A magnitude of exactly 12 counts as inside the band, so an error of 12 after reset gives a duty of 73.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle strobe that marks a new error sample |
| err_code | input | 10 | Signed error code, reference minus measurement |
| duty | output | 10 | Unsigned duty command |
| duty_valid | output | 1 | Pulse that marks a new duty command |

## Verification
The case hardest to reach from the ports is a transient that restarts while the block is settling. The sample after it must use a ratio against the peak of the earlier event, not a fresh one. The stimulus table drives a large negative event and lets it fall inside the band for a few samples. It then pushes a moderate positive error, so that the boosted result depends on the old peak. Saturation at both rails and the exact threshold code are reached by directed runs from a clean reset.

// File: rtl/mapid_pkg.sv
package mapid_pkg;

  typedef enum logic [1:0] {
    ST_QUIET  = 2'd0,
    ST_RISE   = 2'd1,
    ST_FALL   = 2'd2,
    ST_SETTLE = 2'd3
  } err_mode_e;

  // Four-level quantised ratio of magnitude m to peak p, using shifts only.
  function automatic logic [2:0] ratio_level(input int unsigned m, input int unsigned p);
    if ((m << 2) >= ((p << 1) + p)) return 3'd4;
    else if ((m << 1) >= p)         return 3'd3;
    else if ((m << 2) >= p)         return 3'd2;
    else                            return 3'd1;
  endfunction

  // Base gain plus a quarter-step scaled increment.
  function automatic int boosted(input int base, input int delta, input logic [2:0] q);
    return base + ((int'(q) * delta) >>> 2);
  endfunction

  // Velocity-form PID increment.
  function automatic int pid_step(input int kp, input int ki, input int kd,
                                  input int e0, input int e1, input int e2);
    return kp * (e0 - e1) + ki * e0 + kd * (e0 - 2 * e1 + e2);
  endfunction

endpackage

// File: rtl/mapid_classifier.sv
module mapid_classifier
  import mapid_pkg::*;
#(
  parameter int EW         = 10,
  parameter int THRESH     = 12,
  parameter int SETTLE_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_stb,
  input  logic signed [EW-1:0] err,
  output err_mode_e            mode_now,
  output logic [2:0]           level_now
);
  localparam int CNT_W = $clog2(SETTLE_LEN + 1);

  err_mode_e         mode_q;
  logic [EW-1:0]     peak_q, peak_nx, peak_cand, mag_w;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic              over_w;

  always_comb begin
    mag_w     = err[EW-1] ? EW'(-err) : EW'(err);
    over_w    = int'(mag_w) > THRESH;
    peak_cand = (mag_w > peak_q) ? mag_w : peak_q;
    mode_now  = mode_q;
    peak_nx   = peak_q;
    cnt_nx    = cnt_q;
    if (over_w) begin
      mode_now = err[EW-1] ? ST_FALL : ST_RISE;
      peak_nx  = peak_cand;
      cnt_nx   = '0;
    end else begin
      case (mode_q)
        ST_RISE, ST_FALL: begin
          mode_now = ST_SETTLE;
          cnt_nx   = CNT_W'(1);
        end
        ST_SETTLE: begin
          if (int'(cnt_q) < SETTLE_LEN) begin
            mode_now = ST_SETTLE;
            cnt_nx   = cnt_q + CNT_W'(1);
          end else begin
            mode_now = ST_QUIET;
            cnt_nx   = '0;
            peak_nx  = '0;
          end
        end
        default: begin
          mode_now = ST_QUIET;
          cnt_nx   = '0;
          peak_nx  = '0;
        end
      endcase
    end
    case (mode_now)
      ST_RISE, ST_FALL: level_now = ratio_level(int'(mag_w), int'(peak_cand));
      ST_SETTLE:        level_now = 3'd4;
      default:          level_now = 3'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= ST_QUIET;
      peak_q <= '0;
      cnt_q  <= '0;
    end else if (sample_stb) begin
      mode_q <= mode_now;
      peak_q <= peak_nx;
      cnt_q  <= cnt_nx;
    end
  end

  // R7
  quiet_peak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ST_QUIET) |-> (peak_q == '0));
  // R7
  settle_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= SETTLE_LEN);
  // R6
  peak_covers_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && over_w) |=> (peak_q >= $past(mag_w)));
  // R8
  peak_kept_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && over_w && mode_q == ST_SETTLE) |=> (peak_q >= $past(peak_q)));

endmodule

// File: rtl/mapid_gain_sched.sv
module mapid_gain_sched
  import mapid_pkg::*;
#(
  parameter int GW   = 17,
  parameter int KP   = 512,
  parameter int KI   = 26,
  parameter int KD   = 1024,
  parameter int DKP  = 179,
  parameter int DKI  = 77,
  parameter int DKD  = 589,
  parameter int DKP2 = 461,
  parameter int DKI2 = 5,
  parameter int DKD2 = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  err_mode_e            mode,
  input  logic [2:0]           level,
  output logic signed [GW-1:0] kp_eff,
  output logic signed [GW-1:0] ki_eff,
  output logic signed [GW-1:0] kd_eff
);
  int dkp_sel, dki_sel, dkd_sel;

  always_comb begin
    if (mode == ST_SETTLE) begin
      dkp_sel = DKP2; dki_sel = DKI2; dkd_sel = DKD2;
    end else begin
      dkp_sel = DKP;  dki_sel = DKI;  dkd_sel = DKD;
    end
    kp_eff = GW'(boosted(KP, dkp_sel, level));
    ki_eff = GW'(boosted(KI, dki_sel, level));
    kd_eff = GW'(boosted(KD, dkd_sel, level));
  end

  // R5
  quiet_base_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_QUIET) |-> (int'(kp_eff) == KP && int'(ki_eff) == KI && int'(kd_eff) == KD));
  // R7
  settle_no_deriv_boost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_SETTLE) |-> (int'(kd_eff) == KD + DKD2));

endmodule

// File: rtl/mapid_incr_law.sv
module mapid_incr_law
  import mapid_pkg::*;
#(
  parameter int EW   = 10,
  parameter int GW   = 17,
  parameter int FRAC = 8,
  parameter int DW   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_stb,
  input  logic signed [EW-1:0] err,
  input  logic signed [GW-1:0] kp,
  input  logic signed [GW-1:0] ki,
  input  logic signed [GW-1:0] kd,
  output logic [DW-1:0]        duty,
  output logic                 duty_valid
);
  localparam int AW = DW + FRAC;
  localparam logic [AW-1:0] ACC_MAX = {{DW{1'b1}}, {FRAC{1'b0}}};

  logic signed [EW-1:0] e1_q, e2_q;
  logic [AW-1:0]        acc_q, acc_nx;
  logic [DW-1:0]        duty_q;
  logic                 valid_q;
  int                   sum_w;

  always_comb begin
    sum_w = int'(acc_q) + pid_step(int'(kp), int'(ki), int'(kd),
                                   int'(err), int'(e1_q), int'(e2_q));
    if (sum_w < 0)                  acc_nx = '0;
    else if (sum_w > int'(ACC_MAX)) acc_nx = ACC_MAX;
    else                            acc_nx = AW'(sum_w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1_q    <= '0;
      e2_q    <= '0;
      acc_q   <= '0;
      duty_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= sample_stb;
      if (sample_stb) begin
        e2_q   <= e1_q;
        e1_q   <= err;
        acc_q  <= acc_nx;
        duty_q <= acc_nx[AW-1:FRAC];
      end
    end
  end

  assign duty       = duty_q;
  assign duty_valid = valid_q;

  // R2
  valid_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> duty_valid);
  // R2
  valid_only_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> !duty_valid);
  // R2
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(duty));
  // R4
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= ACC_MAX);
  // R3
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> (e2_q == $past(e1_q)));

endmodule

// File: rtl/mapid_comp.sv
module mapid_comp
  import mapid_pkg::*;
#(
  parameter int ERR_W      = 10,
  parameter int COEF_W     = 16,
  parameter int FRAC       = 8,
  parameter int DUTY_W     = 10,
  parameter int THRESH     = 12,
  parameter int SETTLE_LEN = 8,
  parameter int KP         = 512,
  parameter int KI         = 26,
  parameter int KD         = 1024,
  parameter int DKP        = 179,
  parameter int DKI        = 77,
  parameter int DKD        = 589,
  parameter int DKP2       = 461,
  parameter int DKI2       = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_stb,
  input  logic signed [ERR_W-1:0] err_code,
  output logic [DUTY_W-1:0]       duty,
  output logic                    duty_valid
);
  localparam int GW = COEF_W + 1;

  err_mode_e            mode_w;
  logic [2:0]           level_w;
  logic signed [GW-1:0] kp_w, ki_w, kd_w;

  mapid_classifier #(
    .EW(ERR_W), .THRESH(THRESH), .SETTLE_LEN(SETTLE_LEN)
  ) u_class (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .err(err_code),
    .mode_now(mode_w), .level_now(level_w)
  );

  mapid_gain_sched #(
    .GW(GW), .KP(KP), .KI(KI), .KD(KD), .DKP(DKP), .DKI(DKI), .DKD(DKD),
    .DKP2(DKP2), .DKI2(DKI2), .DKD2(0)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .level(level_w),
    .kp_eff(kp_w), .ki_eff(ki_w), .kd_eff(kd_w)
  );

  mapid_incr_law #(
    .EW(ERR_W), .GW(GW), .FRAC(FRAC), .DW(DUTY_W)
  ) u_law (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .err(err_code),
    .kp(kp_w), .ki(ki_w), .kd(kd_w), .duty(duty), .duty_valid(duty_valid)
  );

  // R6
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == ST_RISE || mode_w == ST_FALL) |-> (level_w >= 3'd1 && level_w <= 3'd4));

endmodule

// File: tb/mapid_comp_bench.sv
module mapid_comp_bench;
  localparam int CLK_P = 10;
  localparam int THR = 12;
  localparam int NV = 30;
  localparam int VEC [NV] = '{0, 5, -3, 12, -12, 40, 60, 45, 30, 20,
                              8, 5, 3, 2, 1, 0, 0, 0, 0, 0,
                              -50, -80, -30, -10, 4, 20, 15, 10, 60, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic signed [9:0] err = '0;
  logic [9:0] duty;
  logic valid;
  int nchk = 0, nfail = 0;
  bit done = 0;

  int m_e1, m_e2, m_acc, m_peak, m_cnt, m_mode, exp_duty;

  always #(CLK_P/2) clk = ~clk;

  mapid_comp u_mapid_comp (.clk(clk), .rst_n(rst_n), .sample_stb(stb),
    .err_code(err), .duty(duty), .duty_valid(valid));

  task automatic model_clear();
    m_e1 = 0; m_e2 = 0; m_acc = 0; m_peak = 0; m_cnt = 0; m_mode = 0; exp_duty = 0;
  endtask

  // mode 0 quiet, 1 transient, 2 settling
  task automatic model_step(input int e);
    int mg, q, kp, ki, kd, s;
    mg = (e < 0) ? -e : e;
    kp = 512; ki = 26; kd = 1024;
    if (mg > THR) begin
      if (mg > m_peak) m_peak = mg;
      m_mode = 1; m_cnt = 0;
      if (4 * mg >= 3 * m_peak) q = 4;
      else if (2 * mg >= m_peak) q = 3;
      else if (4 * mg >= m_peak) q = 2;
      else q = 1;
      kp += (q * 179) / 4; ki += (q * 77) / 4; kd += (q * 589) / 4;
    end else if (m_mode == 1 || (m_mode == 2 && m_cnt < 8)) begin
      m_cnt = (m_mode == 1) ? 1 : m_cnt + 1;
      m_mode = 2;
      kp += 461; ki += 5;
    end else begin
      m_mode = 0; m_cnt = 0; m_peak = 0;
    end
    s = m_acc + kp * (e - m_e1) + ki * e + kd * (e - 2 * m_e1 + m_e2);
    if (s < 0) s = 0;
    if (s > 1023 * 256) s = 1023 * 256;
    m_acc = s; m_e2 = m_e1; m_e1 = e; exp_duty = s / 256;
  endtask

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int e, input string req);
    @(negedge clk);
    stb = 1'b1; err = e[9:0];
    model_step(e);
    @(negedge clk);
    stb = 1'b0;
    check(req, int'(duty), exp_duty);
    check("R2 valid pulse", int'(valid), 1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    model_clear();
    check("R1 duty after reset", int'(duty), 0);
    check("R1 valid after reset", int'(valid), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    model_clear();
    do_reset();
    // table walk: quiet, threshold, rise, settle, fall, restart during settling
    for (int i = 0; i < NV; i++) apply(VEC[i], "R3/R5/R6/R7/R8 table");
    @(negedge clk);
    check("R2 valid drops", int'(valid), 0);
    // R2: no strobe leaves duty untouched
    begin
      int held;
      held = int'(duty);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        check("R2 duty stable idle", int'(duty), held);
        check("R2 no valid idle", int'(valid), 0);
      end
    end
    // R4 saturation at both rails
    for (int i = 0; i < 40; i++) apply(300, "R4 upper clamp");
    check("R4 rail high", int'(duty), 1023);
    apply(0, "R4 release from high");
    for (int i = 0; i < 40; i++) apply(-300, "R4 lower clamp");
    check("R4 rail low", int'(duty), 0);
    // R1 history cleared by reset
    do_reset();
    apply(10, "R1 first sample");
    check("R1 fresh result", int'(duty), 61);
    // R9 boundary value stays quiet
    do_reset();
    apply(12, "R9 boundary");
    check("R9 boundary result", int'(duty), 73);
    // R5 one over the threshold boosts
    do_reset();
    apply(13, "R5 just over");
    check("R5 boosted result", int'(duty), 122);
    // R7 settling length then quiet
    for (int i = 0; i < 10; i++) apply(0, "R7 settle run");
    apply(-13, "R5 falling");
    apply(2, "R7 settle entry");
    apply(-13, "R8 restart");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule